// File: doc/BRIEF.md
# Armed Vectored Interrupt Controller

This block gathers service requests from a set of dedicated device status lines and from one shared, active-low request wire, and turns them into a single registered interrupt request with a vector index for a processor core. Each dedicated line is synchronised to the system clock. A per-line edge detector catches rising edges, falling edges, both or neither, and a sticky pending flag holds each caught edge. The shared wire has no latch: it requests for as long as it is held low.

Software controls the block through a small register port. It sets a per-source arm mask and a global enable, and picks each dedicated line's edge mode. It can also read the pending flags and clear them by writing ones. While the global enable is off, requests are held back but not lost. The core sees `irq_o` and `vec_o`. It pulses `irq_ack_i` to take the presented request, and that pulse also clears the served pending flag. A fixed priority picks among simultaneous requests: dedicated source 0 ranks first and the shared wire ranks last.

Top module: `vic_top`

## Requirements
- R1: After synchronous reset, `irq_o` is 0, the arm mask, global enable and all pending flags are 0, and every edge-mode field holds rising edge (01).
- R2: A source whose arm bit is 0 never raises `irq_o`. Its pending flag still latches edges and becomes visible in the pending register.
- R3: With the global enable at 0, `irq_o` stays 0. A request that is pending and armed is raised on the clock after the enable write takes effect.
- R4: Dedicated source i has a 2-bit mode field at bits [2i+1:2i] of the edge register: 00 catches nothing, 01 catches rising edges, 10 catches falling edges, 11 catches both.
- R5: The shared wire requests whenever it reads 0 and bit N of the arm mask is set, using vector N. It has no latch, so `irq_o` drops once the wire returns high. Bit N of the pending register reads 1 while the wire is low.
- R6: Dedicated source i is presented with vector i.
- R7: Lower index means higher priority, and the shared wire is lowest. Requests that are not served stay pending and are presented later in order.
- R8: Writing 1 to bit i of the pending register clears flag i, and writing 0 leaves it unchanged. An acknowledge while vector i (i < N) is presented also clears flag i. An acknowledge of the shared vector clears nothing.
- R9: An edge that is captured in the same cycle as a clear of its flag wins, and the flag stays set.
- R10: While `irq_o` is high, `vec_o` holds its value until an acknowledge arrives or the presented request goes away. After either, `irq_o` is low for at least one cycle before a new vector is chosen.
- R11: Register addresses are: 0 for the arm mask (bits 0..N-1 dedicated, bit N shared), 1 for the global enable (bit 0), 2 for the edge modes, and 3 for pending. Read data appears one clock after the address is presented.
- R12: An input change driven between clock edges sets the pending flag on the third following rising edge, and `irq_o` rises on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_in | input | N_EDGE | Asynchronous dedicated device status lines |
| shared_n | input | 1 | Shared active-low level request wire |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2*N_EDGE | Register write data |
| reg_rdata | output | 2*N_EDGE | Registered read data |
| irq_o | output | 1 | Registered interrupt request to the core |
| vec_o | output | clog2(N_EDGE+1) | Vector of the presented request |
| irq_ack_i | input | 1 | Acknowledge from the core |

## Verification
The bench sweeps every edge mode on every dedicated source in both transition directions. A wrong mode decode shows up there as a flag that sets when it should not, or fails to set when it should. It then holds one vector while a higher-priority edge arrives, which catches a design that swaps vectors under a raised request. It also checks that acknowledges drain the queued requests in fixed priority order with the shared wire last. Timing is checked at exact cycles: the enable write's effect, the synchroniser latency, and a write-one-to-clear landing in the same cycle as a new edge. A design that let the clear win would lose that request. The bench also confirms that the shared wire keeps re-requesting after an acknowledge until it is released, since a design that latched it would stick high.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [1:0] ADDR_ARM  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_EDGE = 2'd2;
  localparam logic [1:0] ADDR_PEND = 2'd3;

  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk) begin
    if (rst) ff_q <= {STAGES{RST_VAL}};
    else     ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/vic_edge_src.sv
module vic_edge_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       async_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       hit_o,
  output logic       pend_o
);
  logic s_w;
  logic prev_q;
  logic pend_q;

  vic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d_i(async_i), .q_o(s_w)
  );

  // mode bit 0 selects rising, bit 1 selects falling
  assign hit_o = (mode_i[0] & s_w & ~prev_q) | (mode_i[1] & ~s_w & prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= s_w;
      if (hit_o)      pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N_REQ = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_REQ-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = N_REQ - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IDX_W'(k);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter  int N_EDGE      = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int VEC_W       = $clog2(N_EDGE + 1),
  localparam int REG_W       = 2 * N_EDGE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EDGE-1:0] edge_in,
  input  logic              shared_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_o,
  input  logic              irq_ack_i,
  output logic [VEC_W-1:0]  vec_o
);
  logic [N_EDGE:0]   arm_q;
  logic              glb_en_q;
  logic [REG_W-1:0]  mode_q;
  logic [N_EDGE-1:0] pend_w;
  logic [N_EDGE-1:0] hit_w;
  logic [N_EDGE-1:0] clr_w;
  logic              shared_s;
  logic [N_EDGE:0]   req_w;
  logic              any_w;
  logic [VEC_W-1:0]  idx_w;
  logic              held_ok;
  logic              irq_q;
  logic [VEC_W-1:0]  vec_q;
  logic [REG_W-1:0]  rdata_q;

  wire pend_wr = reg_we && (reg_addr == ADDR_PEND);
  wire ack_hit = irq_q && irq_ack_i;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q    <= '0;
      glb_en_q <= 1'b0;
      mode_q   <= {N_EDGE{EDGE_RISE}};
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_ARM:  arm_q    <= reg_wdata[N_EDGE:0];
        ADDR_CTRL: glb_en_q <= reg_wdata[0];
        ADDR_EDGE: mode_q   <= reg_wdata;
        default:   ;
      endcase
    end
  end

  // dedicated edge sources
  for (genvar i = 0; i < N_EDGE; i++) begin : g_src
    assign clr_w[i] = (pend_wr && reg_wdata[i]) ||
                      (ack_hit && (vec_q == VEC_W'(i)));
    vic_edge_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst(rst), .async_i(edge_in[i]),
      .mode_i(mode_q[2*i +: 2]), .clr_i(clr_w[i]),
      .hit_o(hit_w[i]), .pend_o(pend_w[i])
    );
  end

  // shared level wire, idles high
  vic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_shared_sync (
    .clk(clk), .rst(rst), .d_i(shared_n), .q_o(shared_s)
  );

  always_comb begin
    req_w = {~shared_s, pend_w} & arm_q;
    if (!glb_en_q) req_w = '0;
  end

  vic_prio #(.N_REQ(N_EDGE + 1), .IDX_W(VEC_W)) u_prio (
    .req_i(req_w), .any_o(any_w), .idx_o(idx_w)
  );

  assign held_ok = req_w[vec_q];

  // request presentation: hold vector while raised
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else if (irq_q) begin
      if (irq_ack_i || !held_ok) irq_q <= 1'b0;
    end else begin
      irq_q <= any_w;
      vec_q <= idx_w;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr)
        ADDR_ARM:  rdata_q <= REG_W'(arm_q);
        ADDR_CTRL: rdata_q <= REG_W'(glb_en_q);
        ADDR_EDGE: rdata_q <= mode_q;
        default:   rdata_q <= REG_W'({~shared_s, pend_w});
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign vec_o     = vec_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int N_EDGE = 4,
  parameter int VEC_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [VEC_W-1:0]  vec,
  input logic              ack,
  input logic              en,
  input logic [N_EDGE:0]   arm,
  input logic [N_EDGE-1:0] pend,
  input logic [N_EDGE-1:0] hit
);
  logic [N_EDGE:0]   arm_p;
  logic [N_EDGE-1:0] req_p;
  logic [N_EDGE:0]   hit_x;
  logic [N_EDGE-1:0] above_mask;

  always_ff @(posedge clk) begin
    arm_p <= arm;
    req_p <= pend & arm[N_EDGE-1:0] & {N_EDGE{en}};
  end

  assign hit_x      = {1'b0, hit};
  assign above_mask = N_EDGE'((1 << vec) - 1);

  assert_arm_gate_R2: assert property (@(posedge clk) disable iff (rst)
    irq |-> arm_p[vec]);

  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);

  assert_vec_range_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (vec <= VEC_W'(N_EDGE)));

  assert_priority_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ((req_p & above_mask) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (irq && ack && (vec < VEC_W'(N_EDGE)) && !hit_x[vec]) |=> !pend[$past(vec)]);

  for (genvar k = 0; k < N_EDGE; k++) begin : g_hit
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (rst)
      hit[k] |=> pend[k]);
  end

  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> (!irq || $stable(vec)));
endmodule

bind vic_top vic_checker #(.N_EDGE(N_EDGE), .VEC_W(VEC_W)) u_vic_checker (
  .clk(clk), .rst(rst), .irq(irq_o), .vec(vec_o), .ack(irq_ack_i),
  .en(glb_en_q), .arm(arm_q), .pend(pend_w), .hit(hit_w)
);

// File: tb/test_vic_top.sv
module test_vic_top;
  localparam int N  = 4;
  localparam int VW = 3;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  edge_in = '0;
  logic          shared_n = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [RW-1:0] reg_wdata = '0;
  logic [RW-1:0] reg_rdata;
  logic          irq;
  logic          ack = 1'b0;
  logic [VW-1:0] vec;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vic_top #(.N_EDGE(N), .SYNC_STAGES(2)) i_vic_top (
    .clk(clk), .rst(rst), .edge_in(edge_in), .shared_n(shared_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq), .irq_ack_i(ack), .vec_o(vec)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    tick(1);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    tick(1);
    v = int'(reg_rdata);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state, R11 map
    check("R1 irq", int'(irq), 0);
    rd(2'd0, v); check("R1 arm", v, 0);
    rd(2'd1, v); check("R1 enable", v, 0);
    rd(2'd2, v); check("R1 edge modes", v, 'h55);
    rd(2'd3, v); check("R1 pending", v, 0);

    // R4 sweep of every mode on every source, both directions (R2 unarmed)
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        wr(2'd2, RW'(m << (2 * i)));
        edge_in[i] = 1'b1;
        tick(5);
        rd(2'd3, v);
        check("R4 rise capture", (v >> i) & 1, m & 1);
        check("R2 unarmed silent", int'(irq), 0);
        wr(2'd3, '1);
        edge_in[i] = 1'b0;
        tick(5);
        rd(2'd3, v);
        check("R4 fall capture", (v >> i) & 1, (m >> 1) & 1);
        wr(2'd3, '1);
      end
    end
    wr(2'd2, 8'h55);

    // R6 vectors, R12 latency, R8 ack clear
    wr(2'd1, 8'd1);
    for (int k = 0; k < N; k++) begin
      wr(2'd0, RW'(1 << k));
      edge_in[k] = 1'b1;
      tick(3);
      check("R12 not yet raised", int'(irq), 0);
      tick(1);
      check("R12 raised", int'(irq), 1);
      check("R6 vector", int'(vec), k);
      pulse_ack();
      check("R10 low after ack", int'(irq), 0);
      rd(2'd3, v);
      check("R8 ack clears", (v >> k) & 1, 0);
      edge_in[k] = 1'b0;
      tick(4);
    end

    // R2 pending latches while unarmed
    wr(2'd0, 8'd0);
    edge_in[2] = 1'b1;
    tick(5);
    check("R2 no irq unarmed", int'(irq), 0);
    rd(2'd3, v);
    check("R2 pending latched", v, 4);

    // R3 enable postpones
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h0F);
    tick(2);
    check("R3 disabled", int'(irq), 0);
    wr(2'd1, 8'd1);
    check("R3 same cycle", int'(irq), 0);
    tick(1);
    check("R3 raised", int'(irq), 1);
    check("R3 vector", int'(vec), 2);

    // R10 hold, R7 priority order, R5 shared last
    edge_in[0] = 1'b1;
    edge_in[3] = 1'b1;
    tick(5);
    check("R10 held irq", int'(irq), 1);
    check("R10 held vector", int'(vec), 2);
    pulse_ack();
    tick(1);
    check("R7 first served", int'(vec), 0);
    wr(2'd0, 8'h1F);
    shared_n = 1'b0;
    tick(3);
    pulse_ack();
    tick(1);
    check("R7 second served", int'(vec), 3);
    pulse_ack();
    tick(1);
    check("R7 shared irq", int'(irq), 1);
    check("R5 shared vector", int'(vec), 4);
    rd(2'd3, v);
    check("R5 live level bit", v, 16);
    pulse_ack();
    check("R10 drop on shared ack", int'(irq), 0);
    tick(1);
    check("R5 re-request", int'(irq), 1);
    check("R5 re-request vector", int'(vec), 4);
    shared_n = 1'b1;
    tick(4);
    check("R5 released", int'(irq), 0);
    rd(2'd3, v);
    check("R5 no latch", v, 0);

    // R2 unarmed shared wire
    wr(2'd0, 8'h0F);
    shared_n = 1'b0;
    tick(5);
    check("R2 shared unarmed", int'(irq), 0);
    shared_n = 1'b1;
    tick(4);

    // R10 request withdrawn by W1C
    edge_in[1] = 1'b1;
    tick(5);
    check("R6 vector one", int'(vec), 1);
    wr(2'd3, 8'd2);
    check("R10 still held", int'(irq), 1);
    tick(1);
    check("R10 withdrawn", int'(irq), 0);

    // R8 W1C selectivity
    wr(2'd1, 8'd0);
    edge_in[1] = 1'b0;
    edge_in[3] = 1'b0;
    tick(4);
    edge_in[1] = 1'b1;
    edge_in[3] = 1'b1;
    tick(5);
    rd(2'd3, v);
    check("R8 two pending", v, 10);
    wr(2'd3, 8'd2);
    rd(2'd3, v);
    check("R8 W1C one bit", v, 8);
    wr(2'd3, '1);

    // R9 edge wins over clear in same cycle
    wr(2'd2, 8'h5D);
    edge_in[1] = 1'b0;
    tick(5);
    rd(2'd3, v);
    check("R4 both-mode fall", (v >> 1) & 1, 1);
    edge_in[1] = 1'b1;
    tick(2);
    wr(2'd3, 8'd2);
    rd(2'd3, v);
    check("R9 edge wins", (v >> 1) & 1, 1);
    wr(2'd3, 8'd2);
    rd(2'd3, v);
    check("R8 plain clear", (v >> 1) & 1, 0);

    finish_run();
  end
endmodule